// File: doc/BRIEF.md
# Base and Limit Address Relocator

This block translates and guards the addresses of one contiguous memory region. A base register gives the physical start of the region and a limit register gives the highest virtual address the running program may use. For every access that arrives with a valid strobe, the block checks the virtual address against the limit and adds the base to it. Both operations run side by side. One cycle later it returns either a physical address with an ok flag, or a fault with the physical address held at zero.

Supervisor software reloads the base and limit through a small write port whenever the active address space changes, for example on a context switch. A privilege input qualifies that port. A write attempted in user mode leaves both registers untouched and is reported on an illegal-write flag.

Top module: `addr_relocator`

## Requirements
- R1: After reset, base and limit are both zero, and `rsp_valid`, `rsp_ok`, `rsp_fault`, `cfg_illegal` and `paddr` are all low. With these values, virtual address 0 is accepted and maps to physical address 0.
- R2: A request whose virtual address is within the limit returns `rsp_ok` high and `paddr` equal to base plus the virtual address, zero-extended to PA_W bits.
- R3: A request whose virtual address is strictly greater than the limit returns `rsp_fault` high, `rsp_ok` low and `paddr` zero.
- R4: A virtual address exactly equal to the limit is accepted.
- R5: If base plus the virtual address does not fit in PA_W bits, the request faults even when it lies within the limit.
- R6: Each cycle with `req_valid` high gives exactly one response, with `rsp_valid` high on the following cycle. A cycle without a request gives `rsp_valid`, `rsp_ok` and `rsp_fault` low on the following cycle.
- R7: When `cfg_we` is high and `priv` is high (supervisor), `cfg_wdata` is loaded into base if `cfg_sel` is 0. If `cfg_sel` is 1, the low VA_W bits of `cfg_wdata` are loaded into limit. Requests issued from the next cycle on use the new value.
- R8: When `cfg_we` is high and `priv` is low (user), neither register changes, and `cfg_illegal` is high on the following cycle. In every other cycle `cfg_illegal` is low on the following cycle.
- R9: `rsp_ok` and `rsp_fault` are never high together, and `paddr` is zero whenever `rsp_fault` is high.
- R10: A request in the same cycle as a supervisor write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 1 | 1 = supervisor mode, 0 = user mode |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 = base, 1 = limit |
| cfg_wdata | input | PA_W | Write data; limit takes the low VA_W bits |
| cfg_illegal | output | 1 | High one cycle after a user-mode write attempt |
| req_valid | input | 1 | Access request strobe |
| vaddr | input | VA_W | Virtual address of the access |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Access allowed; paddr is meaningful |
| rsp_fault | output | 1 | Access rejected: above the limit or the sum overflowed |
| paddr | output | PA_W | Relocated physical address, zero on fault |

## Verification
The assertions assume that `priv`, `cfg_we`, `req_valid` and the data inputs are stable around each rising edge and free of unknown values once reset is released. They also assume that a response and its flags are judged only in the cycle after the strobe. The bench changes every input on the falling edge and samples outputs on the falling edge that follows the capturing rising edge, so every check lines up with the one-cycle response. Writes and requests are raised together on purpose in one scenario to cover the same-cycle ordering.

// File: rtl/addr_relocator.sv
module addr_relocator #(
  parameter int VA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [PA_W-1:0] cfg_wdata,
  output logic            cfg_illegal,
  input  logic            req_valid,
  input  logic [VA_W-1:0] vaddr,
  output logic            rsp_valid,
  output logic            rsp_ok,
  output logic            rsp_fault,
  output logic [PA_W-1:0] paddr
);

  localparam int SUM_W = PA_W + 1;

  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  limit_q;
  logic [SUM_W-1:0] sum;
  logic             over_limit;
  logic             carry_out;
  logic             bad;
  logic             wr_ok;

  // range compare and relocation add are independent paths
  assign over_limit = vaddr > limit_q;
  assign sum        = SUM_W'(base_q) + SUM_W'(vaddr);
  assign carry_out  = sum[PA_W];
  assign bad        = over_limit | carry_out;
  assign wr_ok      = cfg_we & priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_ok) begin
      if (cfg_sel) limit_q <= cfg_wdata[VA_W-1:0];
      else         base_q  <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_illegal <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_fault   <= 1'b0;
      paddr       <= '0;
    end else begin
      cfg_illegal <= cfg_we & ~priv;
      rsp_valid   <= req_valid;
      rsp_ok      <= req_valid & ~bad;
      rsp_fault   <= req_valid & bad;
      paddr       <= (req_valid && !bad) ? sum[PA_W-1:0] : '0;
    end
  end

  p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok && !rsp_fault));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ok && rsp_fault));
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (paddr == '0));
  p_over_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && vaddr > limit_q) |=> (rsp_fault && !rsp_ok));
  p_user_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv) |=> cfg_illegal);
  p_user_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv) |=> ($stable(base_q) && $stable(limit_q)));

endmodule

// File: tb/sim_addr_relocator.sv
module sim_addr_relocator;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 16;
  localparam int PA_W = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            priv = 1'b0;
  logic            cfg_we = 1'b0;
  logic            cfg_sel = 1'b0;
  logic [PA_W-1:0] cfg_wdata = '0;
  logic            cfg_illegal;
  logic            req_valid = 1'b0;
  logic [VA_W-1:0] vaddr = '0;
  logic            rsp_valid, rsp_ok, rsp_fault;
  logic [PA_W-1:0] paddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_relocator #(.VA_W(VA_W), .PA_W(PA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .priv(priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_illegal(cfg_illegal), .req_valid(req_valid),
    .vaddr(vaddr), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_fault(rsp_fault), .paddr(paddr)
  );

  task automatic chk(input bit good, input string tag, input longint act, input longint exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_rsp(input string tag, input bit exp_ok, input logic [PA_W-1:0] exp_pa);
    chk(rsp_valid === 1'b1, {tag, " R6 valid"}, rsp_valid, 1);
    chk(rsp_ok === exp_ok, {tag, " ok"}, rsp_ok, exp_ok);
    chk(rsp_fault === !exp_ok, {tag, " R9 fault"}, rsp_fault, !exp_ok);
    chk(paddr === (exp_ok ? exp_pa : '0), {tag, " paddr"}, paddr, exp_ok ? exp_pa : 0);
  endtask

  task automatic access(input string tag, input logic [VA_W-1:0] va,
                        input bit exp_ok, input logic [PA_W-1:0] exp_pa);
    @(negedge clk);
    req_valid = 1'b1; vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, exp_ok, exp_pa);
  endtask

  task automatic cfg_write(input string tag, input bit sel, input logic [PA_W-1:0] d, input bit p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; priv = p;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(cfg_illegal === !p, {tag, " R8 illegal flag"}, cfg_illegal, !p);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 0 && rsp_ok === 0 && rsp_fault === 0 && cfg_illegal === 0 && paddr === 0,
        "R1 reset outputs", {rsp_valid, rsp_ok, rsp_fault, cfg_illegal}, 0);
    rst_n = 1'b1;
    access("R1 va0 after reset", 16'h0000, 1'b1, 20'h0);
    access("R1 R3 va1 after reset", 16'h0001, 1'b0, 20'h0);
  endtask

  task automatic t_translate();
    cfg_write("R7 base", 1'b0, 20'h01000, 1'b1);
    cfg_write("R7 limit", 1'b1, 20'h00FFF, 1'b1);
    access("R2 R7 inside", 16'h0010, 1'b1, 20'h01010);
    access("R4 at limit", 16'h0FFF, 1'b1, 20'h01FFF);
    access("R3 above limit", 16'h1000, 1'b0, 20'h0);
    access("R3 far above", 16'hFFFF, 1'b0, 20'h0);
  endtask

  task automatic t_user_write();
    cfg_write("R8 user base", 1'b0, 20'h05000, 1'b0);
    cfg_write("R8 user limit", 1'b1, 20'h0FFFF, 1'b0);
    access("R8 base kept", 16'h0010, 1'b1, 20'h01010);
    access("R8 limit kept", 16'h1000, 1'b0, 20'h0);
    @(negedge clk);
    chk(cfg_illegal === 1'b0, "R8 flag clears", cfg_illegal, 0);
  endtask

  task automatic t_carry();
    cfg_write("R5 base", 1'b0, 20'hFFFF0, 1'b1);
    cfg_write("R5 limit", 1'b1, 20'h0FFFF, 1'b1);
    access("R5 top fits", 16'h000F, 1'b1, 20'hFFFFF);
    access("R5 carry out", 16'h0010, 1'b0, 20'h0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 20'h02000; priv = 1'b1;
    req_valid = 1'b1; vaddr = 16'h0005;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check_rsp("R10 old base", 1'b1, 20'hFFFF5);
    access("R10 new base", 16'h0005, 1'b1, 20'h02005);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; vaddr = 16'h0100;
    @(negedge clk);
    check_rsp("R6 first", 1'b1, 20'h02100);
    vaddr = 16'hF000;
    @(negedge clk);
    check_rsp("R6 second", 1'b1, 20'h11000);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 0 && rsp_ok === 0 && rsp_fault === 0, "R6 idle", rsp_valid, 0);
  endtask

  initial begin
    t_reset();
    t_translate();
    t_user_write();
    t_carry();
    t_same_cycle();
    t_back_to_back();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule